// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clocks in a small microcontroller are running. Its own logic runs on an always-on reference clock. It drives an oscillator enable, a CPU clock enable, a clock enable shared by the real-time interrupt and the watchdog, and one clock enable per peripheral. The CPU asks for a low-power state with a stop request or a wait request. A configuration input picks one of two stop flavours:

- **Full stop** turns off the oscillator and every clock.
- **Pseudo-stop** keeps the oscillator running and may keep the timer clock alive.

Wait mode freezes only the CPU. In wait mode each peripheral can gate its own clock through a local disable bit.

Leaving full stop takes an oscillator warm-up. The warm-up is modelled as a start-up count. Its length is taken from an input at the moment of wake-up. Leaving pseudo-stop takes two clock edges. All enables come straight from flops, so they change only at reference clock edges.

Top module: `lp_clk_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released, all enables are 1 (osc_en, cpu_clk_en, tmr_clk_en, every periph_clk_en bit). Asserting rst_n low forces this at once from any low-power state.
- R2: In run, a stop_req sampled with pstop_sel=0 enters full stop. From that edge on, every enable output is 0, including osc_en.
- R3: In full stop, irq_any, rti_evt, wdog_evt, wait_req and stop_req have no effect; all enables stay 0.
- R4: An ext_irq sampled in full stop sets osc_en at that edge. The other enables return to 1 exactly max(N,1) edges later, where N is the osc_start_cnt value sampled at the wake edge.
- R5: In run, a stop_req sampled with pstop_sel=1 enters pseudo-stop: osc_en=1, cpu_clk_en=0, tmr_clk_en equals keep_tmr, and all periph_clk_en bits are 0.
- R6: Pseudo-stop wakes on ext_irq at any time, and on rti_evt or wdog_evt only when keep_tmr=1. All enables are 1 two edges after the event is sampled; on the first of those edges the outputs still show pseudo-stop.
- R7: In run, a wait_req without stop_req enters wait: osc_en=1, cpu_clk_en=0, tmr_clk_en=1. Each periph_clk_en[i] is the inverse of periph_off[i] (bit i = 1 switches peripheral i off), and it follows periph_off one edge later while in wait.
- R8: In wait, irq_any or ext_irq returns all enables to 1 at the edge that samples it.
- R9: In run, periph_off has no effect. When stop_req and wait_req arrive together, stop wins.
- R10: cpu_clk_en is never 1 while osc_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | always-on reference clock |
| rst_n | input | 1 | asynchronous active-low reset |
| stop_req | input | 1 | CPU request to enter a stop state |
| wait_req | input | 1 | CPU request to enter wait |
| pstop_sel | input | 1 | 1 selects pseudo-stop, 0 selects full stop |
| keep_tmr | input | 1 | keep timer clock running in pseudo-stop |
| periph_off | input | NUM_PERIPH | per-peripheral clock disable, honoured in wait |
| ext_irq | input | 1 | external interrupt wake source |
| irq_any | input | 1 | any enabled interrupt, ends wait |
| rti_evt | input | 1 | real-time interrupt event |
| wdog_evt | input | 1 | watchdog event |
| osc_start_cnt | input | CNT_W | oscillator start-up count in cycles |
| osc_en | output | 1 | oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| tmr_clk_en | output | 1 | real-time interrupt / watchdog clock enable |
| periph_clk_en | output | NUM_PERIPH | per-peripheral clock enables |

## Verification
The assertions assume that rti_evt and wdog_evt are meaningful only while the timer clock runs. They also assume that requests are single-cycle pulses presented in run. The stimulus therefore drives every input on the falling edge and holds each wake event for exactly one sampling edge. The only exception is a deliberately held ignored event, which checks R3 and R6. Timing assertions are relative to the internal wake pulses and make no assumption about osc_start_cnt. The bench sweeps a range of counts, including 0 and a long count, and changes the count only while in run.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [2:0] {
    LP_RUN   = 3'd0,
    LP_WAIT  = 3'd1,
    LP_PSTOP = 3'd2,
    LP_FSTOP = 3'd3,
    LP_WARM  = 3'd4,
    LP_PWAKE = 3'd5
  } lp_state_e;

  typedef struct packed {
    logic osc;
    logic cpu;
    logic tmr;
  } core_en_t;

  // core enables wanted for a given state
  function automatic core_en_t core_decode(input lp_state_e s, input logic keep);
    core_en_t e;
    case (s)
      LP_RUN:            e = '{osc: 1'b1, cpu: 1'b1, tmr: 1'b1};
      LP_WAIT:           e = '{osc: 1'b1, cpu: 1'b0, tmr: 1'b1};
      LP_PSTOP, LP_PWAKE: e = '{osc: 1'b1, cpu: 1'b0, tmr: keep};
      LP_WARM:           e = '{osc: 1'b1, cpu: 1'b0, tmr: 1'b0};
      default:           e = '{osc: 1'b0, cpu: 1'b0, tmr: 1'b0};
    endcase
    return e;
  endfunction

  // peripheral enable for one bit
  function automatic logic periph_decode(input lp_state_e s, input logic off_bit);
    case (s)
      LP_RUN:  return 1'b1;
      LP_WAIT: return ~off_bit;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lp_fsm.sv
module lp_fsm
  import lp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stop_req,
  input  logic      wait_req,
  input  logic      pstop_sel,
  input  logic      keep_tmr,
  input  logic      ext_irq,
  input  logic      irq_any,
  input  logic      rti_evt,
  input  logic      wdog_evt,
  input  logic      warm_done,
  output lp_state_e state_q,
  output lp_state_e state_nxt,
  output logic      warm_start,
  output logic      warm_active,
  output logic      pstop_wake,
  output logic      wait_wake
);

  assign warm_active = (state_q == LP_WARM);
  assign warm_start  = (state_q == LP_FSTOP) && ext_irq;
  assign pstop_wake  = (state_q == LP_PSTOP) &&
                       (ext_irq || (keep_tmr && (rti_evt || wdog_evt)));
  assign wait_wake   = (state_q == LP_WAIT) && (irq_any || ext_irq);

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      LP_RUN: begin
        if (stop_req)      state_nxt = pstop_sel ? LP_PSTOP : LP_FSTOP;
        else if (wait_req) state_nxt = LP_WAIT;
      end
      LP_WAIT:  if (wait_wake)  state_nxt = LP_RUN;
      LP_PSTOP: if (pstop_wake) state_nxt = LP_PWAKE;
      LP_PWAKE: state_nxt = LP_RUN;
      LP_FSTOP: if (warm_start) state_nxt = LP_WARM;
      LP_WARM:  if (warm_done)  state_nxt = LP_RUN;
      default:  state_nxt = LP_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LP_RUN;
    else        state_q <= state_nxt;
  end

  assert_fstop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LP_FSTOP && !ext_irq) |=> (state_q == LP_FSTOP));

  assert_pwake_to_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LP_PWAKE) |=> (state_q == LP_RUN));

endmodule

// File: rtl/lp_warm_cnt.sv
module lp_warm_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             active,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  // last warm-up cycle when one or zero counts remain
  function automatic logic last_tick(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  assign done = active && last_tick(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load)                     cnt_q <= load_val;
    else if (active && cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assert_warm_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && !last_tick(cnt_q)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/lp_en_reg.sv
module lp_en_reg
  import lp_pkg::*;
#(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  lp_state_e             state_nxt,
  input  logic                  keep_tmr,
  input  logic [NUM_PERIPH-1:0] periph_off,
  output logic                  osc_en,
  output logic                  cpu_clk_en,
  output logic                  tmr_clk_en,
  output logic [NUM_PERIPH-1:0] periph_clk_en
);

  core_en_t core_d;
  assign core_d = core_decode(state_nxt, keep_tmr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en     <= 1'b1;
      cpu_clk_en <= 1'b1;
      tmr_clk_en <= 1'b1;
    end else begin
      osc_en     <= core_d.osc;
      cpu_clk_en <= core_d.cpu;
      tmr_clk_en <= core_d.tmr;
    end
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) periph_clk_en[i] <= 1'b1;
      else        periph_clk_en[i] <= periph_decode(state_nxt, periph_off[i]);
    end
  end

endmodule

// File: rtl/lp_clk_ctrl.sv
module lp_clk_ctrl
  import lp_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stop_req,
  input  logic                  wait_req,
  input  logic                  pstop_sel,
  input  logic                  keep_tmr,
  input  logic [NUM_PERIPH-1:0] periph_off,
  input  logic                  ext_irq,
  input  logic                  irq_any,
  input  logic                  rti_evt,
  input  logic                  wdog_evt,
  input  logic [CNT_W-1:0]      osc_start_cnt,
  output logic                  osc_en,
  output logic                  cpu_clk_en,
  output logic                  tmr_clk_en,
  output logic [NUM_PERIPH-1:0] periph_clk_en
);

  localparam logic [NUM_PERIPH-1:0] ALL_ON = '1;

  lp_state_e state_q, state_nxt;
  logic warm_start, warm_active, warm_done, pstop_wake, wait_wake;

  lp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .stop_req(stop_req), .wait_req(wait_req), .pstop_sel(pstop_sel),
    .keep_tmr(keep_tmr), .ext_irq(ext_irq), .irq_any(irq_any),
    .rti_evt(rti_evt), .wdog_evt(wdog_evt), .warm_done(warm_done),
    .state_q(state_q), .state_nxt(state_nxt),
    .warm_start(warm_start), .warm_active(warm_active),
    .pstop_wake(pstop_wake), .wait_wake(wait_wake)
  );

  lp_warm_cnt #(.CNT_W(CNT_W)) u_warm (
    .clk(clk), .rst_n(rst_n),
    .load(warm_start), .load_val(osc_start_cnt),
    .active(warm_active), .done(warm_done)
  );

  lp_en_reg #(.NUM_PERIPH(NUM_PERIPH)) u_en (
    .clk(clk), .rst_n(rst_n),
    .state_nxt(state_nxt), .keep_tmr(keep_tmr), .periph_off(periph_off),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en),
    .periph_clk_en(periph_clk_en)
  );

  assert_no_clock_without_osc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!cpu_clk_en && !tmr_clk_en && periph_clk_en == '0));

  assert_cpu_needs_osc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> osc_en);

  assert_pstop_wake_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pstop_wake |=> ##1 (cpu_clk_en && periph_clk_en == ALL_ON));

  assert_wait_wake_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wait_wake |=> (cpu_clk_en && tmr_clk_en && periph_clk_en == ALL_ON));

  assert_warm_osc_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    warm_start |=> (osc_en && !cpu_clk_en));

endmodule

// File: tb/tb_lp_clk_ctrl.sv
module tb_lp_clk_ctrl;

  localparam int NP = 4;
  localparam int CW = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, wait_req = 0, pstop_sel = 0, keep_tmr = 0;
  logic [NP-1:0] periph_off = '0;
  logic ext_irq = 0, irq_any = 0, rti_evt = 0, wdog_evt = 0;
  logic [CW-1:0] osc_start_cnt = '0;
  logic osc_en, cpu_clk_en, tmr_clk_en;
  logic [NP-1:0] periph_clk_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  lp_clk_ctrl #(.NUM_PERIPH(NP), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
    .pstop_sel(pstop_sel), .keep_tmr(keep_tmr), .periph_off(periph_off),
    .ext_irq(ext_irq), .irq_any(irq_any), .rti_evt(rti_evt), .wdog_evt(wdog_evt),
    .osc_start_cnt(osc_start_cnt), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .tmr_clk_en(tmr_clk_en), .periph_clk_en(periph_clk_en)
  );

  function automatic logic [NP+2:0] pack(input logic o, input logic c, input logic t,
                                         input logic [NP-1:0] p);
    return {o, c, t, p};
  endfunction

  function automatic logic [NP+2:0] obs();
    return {osc_en, cpu_clk_en, tmr_clk_en, periph_clk_en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter_stop(input logic psel, input logic keep);
    pstop_sel = psel; keep_tmr = keep; stop_req = 1'b1;
    cyc();
    stop_req = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", cycles, WATCHDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    #1 chk("R1 in reset", obs(), pack(1, 1, 1, '1));
    cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1 after reset", obs(), pack(1, 1, 1, '1));

    // R2/R3/R4: full stop sweep over start-up counts
    for (int n = 0; n <= 14; n++) begin
      int cnt_val;
      int lat;
      cnt_val = (n == 14) ? 4096 : n;
      osc_start_cnt = CW'(cnt_val);
      enter_stop(1'b0, 1'b0);
      chk("R2 full stop all off", obs(), '0);
      if (n < 3) begin
        irq_any = 1; rti_evt = 1; wdog_evt = 1; wait_req = 1; stop_req = 1;
        repeat (3) begin
          cyc();
          chk("R3 full stop ignores other sources", obs(), '0);
        end
        irq_any = 0; rti_evt = 0; wdog_evt = 0; wait_req = 0; stop_req = 0;
      end
      ext_irq = 1'b1;
      cyc();
      ext_irq = 1'b0;
      chk("R4 osc first", obs(), pack(1, 0, 0, '0));
      lat = 0;
      while (!cpu_clk_en && lat < 5000) begin
        cyc();
        lat++;
      end
      chk("R4 wake latency", lat, (cnt_val < 1) ? 1 : cnt_val);
      chk("R4 all back on", obs(), pack(1, 1, 1, '1));
    end

    // R5/R6: pseudo-stop, each source and timer retention choice
    for (int keep = 0; keep < 2; keep++) begin
      for (int src = 0; src < 3; src++) begin
        enter_stop(1'b1, keep[0]);
        chk("R5 pseudo-stop outputs", obs(), pack(1, 0, keep[0], '0));
        if (src == 0) ext_irq = 1'b1;
        if (src == 1) rti_evt = 1'b1;
        if (src == 2) wdog_evt = 1'b1;
        if (src == 0 || keep == 1) begin
          cyc();
          ext_irq = 0; rti_evt = 0; wdog_evt = 0;
          chk("R6 first wake edge", obs(), pack(1, 0, keep[0], '0));
          cyc();
          chk("R6 awake after two edges", obs(), pack(1, 1, 1, '1));
        end else begin
          repeat (3) begin
            cyc();
            chk("R6 timer event ignored", obs(), pack(1, 0, 0, '0));
          end
          rti_evt = 0; wdog_evt = 0;
          ext_irq = 1'b1;
          cyc();
          ext_irq = 1'b0;
          cyc();
          chk("R6 ext wake after ignored", obs(), pack(1, 1, 1, '1));
        end
      end
    end

    // R7/R8/R9: wait sweep over all disable patterns
    for (int p = 0; p < (1 << NP); p++) begin
      periph_off = NP'(p);
      cyc();
      chk("R9 disable ignored in run", obs(), pack(1, 1, 1, '1));
      wait_req = 1'b1;
      cyc();
      wait_req = 1'b0;
      chk("R7 wait outputs", obs(), pack(1, 0, 1, ~NP'(p)));
      periph_off = ~NP'(p);
      cyc();
      chk("R7 live disable", obs(), pack(1, 0, 1, NP'(p)));
      if (p % 2 == 0) irq_any = 1'b1; else ext_irq = 1'b1;
      cyc();
      irq_any = 0; ext_irq = 0;
      chk("R8 wait wake next edge", obs(), pack(1, 1, 1, '1));
      periph_off = '0;
    end

    // R9: stop wins over wait
    osc_start_cnt = CW'(3);
    pstop_sel = 0; stop_req = 1; wait_req = 1;
    cyc();
    stop_req = 0; wait_req = 0;
    chk("R9 stop priority", obs(), '0);
    irq_any = 1'b1;
    cyc();
    irq_any = 1'b0;
    chk("R9 not in wait", obs(), '0);
    ext_irq = 1'b1;
    cyc();
    ext_irq = 1'b0;
    repeat (3) cyc();
    chk("R9 back to run", obs(), pack(1, 1, 1, '1));

    // R1: reset from low-power states
    enter_stop(1'b0, 1'b0);
    rst_n = 1'b0;
    #1 chk("R1 reset from full stop", obs(), pack(1, 1, 1, '1));
    cyc();
    rst_n = 1'b1;
    cyc();
    enter_stop(1'b1, 1'b0);
    rst_n = 1'b0;
    #1 chk("R1 reset from pseudo-stop", obs(), pack(1, 1, 1, '1));
    cyc();
    rst_n = 1'b1;
    cyc();
    chk("R10 run after reset", {cpu_clk_en, osc_en}, 2'b11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule